// File: doc/BRIEF.md
# Fall-Through FIFO with Programmable Level Flags

A single-clock synchronous FIFO holding 36-bit words, with a power-of-two depth N. A mode input, sampled only while master reset is held, picks one of two read behaviours. In standard mode a read enable copies the oldest word into the output register at the clock edge, and the two end-of-range pins act as active-low empty and full flags. In fall-through mode the oldest word is already waiting on the output, with no read enable needed. Read enable consumes that word and brings the next one forward. The output register adds one word of storage, so capacity becomes N+1 words. The same two pins then act as an active-low "output holds data" flag and an active-low "can accept a write" flag.

Three more active-low level flags report the fill: half-full, almost-empty and almost-full. The thresholds of almost-empty and almost-full come from two offset registers, each log2(N) bits wide. The offsets are loaded one bit per clock through a serial input while a serial enable is high. Every threshold moves up by one word in fall-through mode, to account for the output register. A partial reset empties the FIFO but keeps the mode and the offsets. A master reset also samples the mode again and restores both offsets to 127.

Top module: `fwft_fifo`

## Requirements
- R1: While `mrstN` is low the mode is taken from `modeSel` (0 = standard, 1 = fall-through). It does not change again until the next master reset.
- R2: In standard mode `emptyOrN` is low exactly when 0 words are held and `fullIrN` is low exactly when N words are held. A read with `ren` high presents the oldest word on `dout` after that clock edge.
- R3: In fall-through mode the first word written appears on `dout`, with `emptyOrN` low, after its write edge and with `ren` low. Each accepted read replaces `dout` with the next word, and `emptyOrN` goes high once no word is left.
- R4: In fall-through mode the capacity is N+1 words: `fullIrN` is low while fewer than N+1 words are held and high at N+1.
- R5: `halfFullN` is low when the count is at least N/2+1 (standard) or N/2+2 (fall-through).
- R6: With empty offset n, `almostEmptyN` is low when the count is at most n (standard) or n+1 (fall-through), and high above that.
- R7: With full offset m, `almostFullN` is low when the count is at least N-m (standard) or N+1-m (fall-through).
- R8: Each clock with `serEn` high shifts `serIn` into the offsets. Over 2*log2(N) clocks the first bit is the empty-offset LSB, the empty offset fills upward, then the full offset follows from its LSB and the last bit is the full-offset MSB.
- R9: A partial reset (`prstN` low) empties the FIFO and keeps the mode and both offsets. A master reset empties it and sets both offsets to 127.
- R10: A write when no space is left and a read when no word is held are ignored: count, data order and flags are unchanged.
- R11: All flags are registered. They take their new value at the same clock edge that accepts the write or read changing the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrstN | input | 1 | Master reset, active low, synchronous |
| prstN | input | 1 | Partial reset, active low, synchronous |
| modeSel | input | 1 | Mode sampled during master reset: 1 = fall-through |
| wen | input | 1 | Write enable |
| din | input | 36 | Write data |
| ren | input | 1 | Read enable |
| serEn | input | 1 | Serial offset load enable |
| serIn | input | 1 | Serial offset data bit |
| dout | output | 36 | Output data register |
| emptyOrN | output | 1 | Standard: empty (low). Fall-through: output word valid (low) |
| fullIrN | output | 1 | Standard: full (low). Fall-through: ready for a write (low) |
| halfFullN | output | 1 | Half-full, active low |
| almostEmptyN | output | 1 | Almost-empty, active low |
| almostFullN | output | 1 | Almost-full, active low |

## Verification
On every cycle the assertions check four things. The count never goes past the capacity of the current mode. In fall-through mode the output register is never empty while memory still holds words. Writes when full and reads when empty leave the state alone, and the mode cannot change outside master reset. The bench scenarios cover what needs a known history. They show where each level flag changes in both modes with asymmetric offsets, which proves the serial bit order. They also show the fall-through timing of the first word and that a partial reset keeps the offsets while a master reset restores the defaults.

// File: rtl/fwft_fifo_pkg.sv
package fwft_fifo_pkg;
  // strobes from control to datapath for one clock
  typedef struct packed {
    logic push;     // store din in memory
    logic pop;      // move memory head into dout
    logic bypass;   // load din straight into dout
    logic clrPtrs;  // empty the queue
  } dpCtrlT;
endpackage

// File: rtl/fwft_fifo_dp.sv
module fwft_fifo_dp
  import fwft_fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  dpCtrlT            ctl,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;

  always_ff @(posedge clk) begin
    if (ctl.push && !ctl.clrPtrs) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (ctl.clrPtrs) begin
      wrPtr <= '0;
      rdPtr <= '0;
      dout  <= '0;
    end else begin
      if (ctl.push) wrPtr <= wrPtr + 1'b1;
      if (ctl.pop) begin
        dout  <= mem[rdPtr];
        rdPtr <= rdPtr + 1'b1;
      end else if (ctl.bypass) begin
        dout <= din;
      end
    end
  end

  // R3
  one_output_source_chk: assert property (@(posedge clk) disable iff (ctl.clrPtrs)
    $onehot0({ctl.pop, ctl.bypass}));
endmodule

// File: rtl/fwft_fifo_ctrl.sv
module fwft_fifo_ctrl
  import fwft_fifo_pkg::*;
#(
  parameter int DEPTH         = 128,
  parameter int DEF_EMPTY_OFF = 127,
  parameter int DEF_FULL_OFF  = 127,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic   clk,
  input  logic   mrstN,
  input  logic   prstN,
  input  logic   modeSel,
  input  logic   wen,
  input  logic   ren,
  input  logic   serEn,
  input  logic   serIn,
  output dpCtrlT ctl,
  output logic   emptyOrN,
  output logic   fullIrN,
  output logic   halfFullN,
  output logic   almostEmptyN,
  output logic   almostFullN
);
  localparam logic [CW-1:0] CAP_STD  = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_FWFT = CW'(DEPTH + 1);
  localparam logic [CW-1:0] HF_STD   = CW'(DEPTH / 2 + 1);
  localparam logic [CW-1:0] HF_FWFT  = CW'(DEPTH / 2 + 2);
  localparam logic [2*AW-1:0] OFF_DEF = {AW'(DEF_FULL_OFF), AW'(DEF_EMPTY_OFF)};

  logic          fwftMode;
  logic [CW-1:0] count, countNext;
  logic [CW-1:0] memCount, memCountNext;
  logic          outValid, outValidNext;
  logic [2*AW-1:0] offSr;

  logic wrOk, rdOk, loadOut, memHas, clrAll;
  logic [CW-1:0] cap;

  assign clrAll = !mrstN || !prstN;

  always_comb begin
    cap     = fwftMode ? CAP_FWFT : CAP_STD;
    memHas  = (memCount != '0);
    wrOk    = wen && (count < cap);
    rdOk    = fwftMode ? (ren && outValid) : (ren && count != '0);
    loadOut = fwftMode && (!outValid || rdOk);
    ctl.pop     = fwftMode ? (loadOut && memHas) : rdOk;
    ctl.bypass  = loadOut && !memHas && wrOk;
    ctl.push    = wrOk && !ctl.bypass;
    ctl.clrPtrs = clrAll;
    outValidNext = !fwftMode ? 1'b0 : (loadOut ? (memHas || wrOk) : 1'b1);
    memCountNext = memCount + CW'(ctl.push) - CW'(ctl.pop);
    countNext    = count + CW'(wrOk) - CW'(rdOk);
  end

  always_ff @(posedge clk) begin
    if (!mrstN) fwftMode <= modeSel;
    if (clrAll) begin
      count    <= '0;
      memCount <= '0;
      outValid <= 1'b0;
    end else begin
      count    <= countNext;
      memCount <= memCountNext;
      outValid <= outValidNext;
    end
  end

  // serial offsets: shifted in from the top, first bit ends at bit 0
  always_ff @(posedge clk) begin
    if (!mrstN)     offSr <= OFF_DEF;
    else if (serEn) offSr <= {serIn, offSr[2*AW-1:1]};
  end

  // flags computed from the state the edge will leave behind
  logic          mF, ovF;
  logic [CW-1:0] cntF, hfThr;
  logic [AW-1:0] eOff, fOff;
  logic [CW:0]   paeThr, pafThr;

  always_comb begin
    mF   = !mrstN ? modeSel : fwftMode;
    cntF = clrAll ? '0 : countNext;
    ovF  = clrAll ? 1'b0 : outValidNext;
    eOff = !mrstN ? OFF_DEF[AW-1:0]    : offSr[AW-1:0];
    fOff = !mrstN ? OFF_DEF[2*AW-1:AW] : offSr[2*AW-1:AW];
    hfThr  = mF ? HF_FWFT : HF_STD;
    paeThr = (CW+1)'(eOff) + (CW+1)'(mF);
    pafThr = (CW+1)'(DEPTH) - (CW+1)'(fOff) + (CW+1)'(mF);
  end

  always_ff @(posedge clk) begin
    emptyOrN     <= mF ? !ovF : (cntF != '0);
    fullIrN      <= mF ? (cntF == CAP_FWFT) : (cntF != CAP_STD);
    halfFullN    <= !(cntF >= hfThr);
    almostEmptyN <= !({1'b0, cntF} <= paeThr);
    almostFullN  <= !({1'b0, cntF} >= pafThr);
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!mrstN)
    count <= (fwftMode ? CAP_FWFT : CAP_STD));

  // R3
  head_loaded_chk: assert property (@(posedge clk) disable iff (!mrstN)
    (fwftMode && !outValid) |-> (memCount == '0));

  // R10
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (!mrstN)
    (!fwftMode && prstN && !fullIrN && wen && !ren) |=> (count == $past(count)));

  // R10
  empty_read_ignored_chk: assert property (@(posedge clk) disable iff (!mrstN)
    (!fwftMode && prstN && !emptyOrN && ren && !wen) |=> !emptyOrN);

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!mrstN)
    mrstN |=> (fwftMode == $past(fwftMode)));
endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo
  import fwft_fifo_pkg::*;
#(
  parameter int DATA_W        = 36,
  parameter int DEPTH         = 128,
  parameter int DEF_EMPTY_OFF = 127,
  parameter int DEF_FULL_OFF  = 127
) (
  input  logic              clk,
  input  logic              mrstN,
  input  logic              prstN,
  input  logic              modeSel,
  input  logic              wen,
  input  logic [DATA_W-1:0] din,
  input  logic              ren,
  input  logic              serEn,
  input  logic              serIn,
  output logic [DATA_W-1:0] dout,
  output logic              emptyOrN,
  output logic              fullIrN,
  output logic              halfFullN,
  output logic              almostEmptyN,
  output logic              almostFullN
);
  dpCtrlT ctl;

  fwft_fifo_ctrl #(
    .DEPTH(DEPTH), .DEF_EMPTY_OFF(DEF_EMPTY_OFF), .DEF_FULL_OFF(DEF_FULL_OFF)
  ) u_ctrl (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .modeSel(modeSel),
    .wen(wen), .ren(ren), .serEn(serEn), .serIn(serIn), .ctl(ctl),
    .emptyOrN(emptyOrN), .fullIrN(fullIrN), .halfFullN(halfFullN),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  fwft_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .ctl(ctl), .din(din), .dout(dout)
  );
endmodule

// File: tb/fwft_fifo_tb.sv
module fwft_fifo_tb;
  localparam int N = 128;

  logic clk = 1'b0;
  logic mrstN = 1'b0, prstN = 1'b1, modeSel = 1'b0;
  logic wen = 1'b0, ren = 1'b0, serEn = 1'b0, serIn = 1'b0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic emptyOrN, fullIrN, halfFullN, almostEmptyN, almostFullN;

  always #4 clk = ~clk;

  fwft_fifo u_dut (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .modeSel(modeSel),
    .wen(wen), .din(din), .ren(ren), .serEn(serEn), .serIn(serIn),
    .dout(dout), .emptyOrN(emptyOrN), .fullIrN(fullIrN),
    .halfFullN(halfFullN), .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  int checks = 0, fails = 0;
  int wrSeq = 0, rdSeq = 0, expCount = 0;
  logic curMode = 1'b0;

  // vector: {mode, writes, reads, flags {emptyOrN,fullIrN,halfFullN,almostEmptyN,almostFullN}}
  localparam logic [21:0] VEC [24] = '{
    {1'b0, 8'd1,  8'd0,   5'b11101}, {1'b0, 8'd2,  8'd0,   5'b11101},
    {1'b0, 8'd1,  8'd0,   5'b11111}, {1'b0, 8'd60, 8'd0,   5'b11111},
    {1'b0, 8'd1,  8'd0,   5'b11011}, {1'b0, 8'd57, 8'd0,   5'b11011},
    {1'b0, 8'd1,  8'd0,   5'b11010}, {1'b0, 8'd5,  8'd0,   5'b10010},
    {1'b0, 8'd1,  8'd0,   5'b10010}, {1'b0, 8'd0,  8'd1,   5'b11010},
    {1'b0, 8'd0,  8'd127, 5'b01101}, {1'b0, 8'd0,  8'd1,   5'b01101},
    {1'b1, 8'd1,  8'd0,   5'b00101}, {1'b1, 8'd3,  8'd0,   5'b00101},
    {1'b1, 8'd1,  8'd0,   5'b00111}, {1'b1, 8'd60, 8'd0,   5'b00111},
    {1'b1, 8'd1,  8'd0,   5'b00011}, {1'b1, 8'd57, 8'd0,   5'b00011},
    {1'b1, 8'd1,  8'd0,   5'b00010}, {1'b1, 8'd5,  8'd0,   5'b01010},
    {1'b1, 8'd1,  8'd0,   5'b01010}, {1'b1, 8'd0,  8'd1,   5'b00010},
    {1'b1, 8'd0,  8'd128, 5'b10101}, {1'b1, 8'd0,  8'd1,   5'b10101}
  };

  function automatic logic [35:0] val(int s);
    return 36'h9_0000_0000 | 36'(s);
  endfunction

  function automatic logic [4:0] flags();
    return {emptyOrN, fullIrN, halfFullN, almostEmptyN, almostFullN};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic masterReset(logic m);
    mrstN = 1'b0; modeSel = m;
    tick(); tick();
    mrstN = 1'b1;
    tick();
    curMode = m; expCount = 0; rdSeq = wrSeq;
  endtask

  task automatic loadOffsets(logic [6:0] n, logic [6:0] m);
    for (int i = 0; i < 14; i++) begin
      serEn = 1'b1;
      serIn = (i < 7) ? n[i] : m[i-7];
      tick();
    end
    serEn = 1'b0;
    tick();
  endtask

  task automatic doWrite(int k);
    for (int i = 0; i < k; i++) begin
      wen = 1'b1; din = val(wrSeq);
      tick();
      wen = 1'b0;
      if (expCount < (curMode ? N + 1 : N)) begin
        wrSeq++; expCount++;
      end
    end
  endtask

  task automatic doRead(int k);
    for (int i = 0; i < k; i++) begin
      if (curMode && expCount > 0) chk("R3 head on dout before read", dout, val(rdSeq));
      ren = 1'b1;
      tick();
      ren = 1'b0;
      if (expCount > 0) begin
        if (!curMode) chk("R2 read data", dout, val(rdSeq));
        rdSeq++; expCount--;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic first;
    // reset state in both modes
    masterReset(1'b0);
    chk("R1 R11 reset flags standard", flags(), 5'b01101);
    masterReset(1'b1);
    chk("R1 reset flags fall-through", flags(), 5'b10101);

    // table walk: R2 R4 R5 R6 R7 R8 R10 R11 with offsets n=3, m=5
    first = 1'b1;
    foreach (VEC[i]) begin
      if (first || VEC[i][21] != curMode) begin
        masterReset(VEC[i][21]);
        loadOffsets(7'd3, 7'd5);
        first = 1'b0;
      end
      doWrite(int'(VEC[i][20:13]));
      doRead(int'(VEC[i][12:5]));
      chk($sformatf("R5 R6 R7 R8 R10 R11 flags vec %0d", i), flags(), VEC[i][4:0]);
    end

    // R3: fall-through without read enable, default offsets (R9)
    masterReset(1'b1);
    doWrite(1);
    chk("R3 first word falls through", dout, val(rdSeq));
    chk("R3 output ready low", emptyOrN, 1'b0);
    chk("R9 default full offset, count 1", almostFullN, 1'b1);
    doWrite(1);
    chk("R3 head held without read", dout, val(rdSeq));
    chk("R9 default full offset, count 2", almostFullN, 1'b0);
    chk("R9 default empty offset", almostEmptyN, 1'b0);
    doRead(1);
    chk("R3 read advances", dout, val(rdSeq));
    doRead(1);
    chk("R3 output ready high after last", emptyOrN, 1'b1);

    // R9: partial reset keeps mode and offsets
    masterReset(1'b1);
    loadOffsets(7'd3, 7'd5);
    doWrite(10);
    prstN = 1'b0;
    tick();
    prstN = 1'b1;
    tick();
    expCount = 0; rdSeq = wrSeq;
    chk("R9 partial reset empties, mode kept", flags(), 5'b10101);
    doWrite(4);
    chk("R9 data after partial reset", dout, val(rdSeq));
    chk("R9 empty offset kept, count 4", almostEmptyN, 1'b0);
    doWrite(1);
    chk("R9 empty offset kept, count 5", almostEmptyN, 1'b1);

    // R9: master reset restores default offsets, standard mode
    masterReset(1'b0);
    doWrite(127);
    chk("R9 default empty offset at 127", almostEmptyN, 1'b0);
    doWrite(1);
    chk("R9 default empty offset at 128", almostEmptyN, 1'b1);
    chk("R2 full at N", fullIrN, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule